// File: doc/BRIEF.md
# UART Register Bank

This block is the software-visible register file of a 16550-style serial port. It sits on a simple synchronous word-addressed bus and turns reads and writes into accesses to the divisor latch, interrupt enable, line control, modem control, line status, scratch and global control registers. The registers sit on a 4-byte stride. Serial bit timing, baud generation, FIFOs and DMA are handled elsewhere. This block only holds state and moves bytes.

Transmit bytes leave as single-cycle pulses on a byte-stream output. Receive bytes come from a byte-stream input, which is consumed only when software reads the receive register. A one-byte holding register implements internal loopback. Two event outputs tell an interrupt controller that a byte was sent or that receive data is waiting.

A request is presented for one cycle. Read data and the error code are registered and appear in the following cycle. Only bits 7:0 of each register are significant, and bits 15:8 always read as zero.

Top module: `uart_regbank`

## Requirements
- R1: After reset, reads return the following values: divisor low 0x0001, divisor high 0, interrupt enable 0, identification (offset 0x08) 0x0001, line control 0, modem control 0, scratch 0, global control 0. The stored line status is 0x0060.
- R2: Line-control bit 7 selects the divisor view. When it is set, offset 0x00 is divisor low and offset 0x04 is divisor high. When it is clear, offset 0x00 is receive on read and transmit on write, and offset 0x04 is interrupt enable. A divisor write produces no transmit pulse.
- R3: Line control (0x0C), modem control (0x10), scratch (0x1C) and global control (0x24) store bits 7:0 of a write, and bits 15:8 read as zero. Writes to identification (0x08), line status (0x14) and modem status (0x18) have no effect, and modem status reads as 0.
- R4: A line-status read (0x14) returns the stored value OR'd with live status. Live status is bit 0 data ready, bit 5 holding empty and bit 6 transmitter empty; bits 5 and 6 both follow `tx_ready`. The read then clears the stored value to zero.
- R5: A transmit write puts bits 7:0 of the write data on `tx_data` with a one-cycle `tx_valid` pulse in the following cycle.
- R6: A transmit write made while interrupt-enable bit 1 is set also pulses `ev_tx` in the same cycle as `tx_valid`.
- R7: When modem-control bit 4 (loopback) is set, a transmit write also saves the byte in a holding register. The next receive read returns that byte and empties the holding register.
- R8: While loopback is on, the external receive input is ignored: it neither sets data ready nor is consumed. A receive read with nothing held returns the previous receive value.
- R9: Without loopback, a receive read while `rx_valid` is high returns `rx_data` and asserts `rx_take` in the request cycle. With no data available, the read returns the previous receive value and `rx_take` stays low.
- R10: `ev_rx` is high one cycle after interrupt-enable bit 0 and data ready are both high, and falls one cycle after either of them drops.
- R11: An access whose size code is not 1 (16-bit) gets error 2'b01. A 16-bit access to an offset that is not defined (beyond 0x24, the 0x20 slot, or not 4-byte aligned) gets error 2'b10. The width check takes priority. A rejected access changes no register and drives no stream.
- R12: Line-status bit 0 is set when the holding register is full, or when loopback is off and `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_size | input | 2 | Access size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| bus_err | output | 2 | Error code, valid the cycle after a request |
| tx_data | output | BW | Transmitted byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_ready | input | 1 | Transmitter idle, shown as holding empty and transmitter empty |
| rx_data | input | BW | Waiting receive byte |
| rx_valid | input | 1 | A receive byte is waiting |
| rx_take | output | 1 | Receive byte consumed this cycle |
| ev_tx | output | 1 | Transmit event pulse |
| ev_rx | output | 1 | Receive event level |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that a request lasts exactly one cycle. The stimulus drives every request from one task, which raises exactly one of the two strobes for a single cycle and then clears both. The checks also assume that `rx_valid` stays high until `rx_take` is seen. The bench changes the receive stream only between requests, and drops `rx_valid` after each consuming read.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [1:0]    bus_err,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [BW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_take,
  output logic          ev_tx,
  output logic          ev_rx
);
  localparam int SL_DATA = 0, SL_IEN = 1, SL_IDENT = 2, SL_LCTL = 3, SL_MCTL = 4;
  localparam int SL_LSTAT = 5, SL_MSTAT = 6, SL_SCR = 7, SL_GCTL = 9;
  localparam logic [1:0] SZ16 = 2'd1;
  localparam int DLAB_BIT = 7, LOOP_BIT = 4;

  logic [BW-1:0] dll, dlh, ien, lctl, mctl, lstat, scr, gctl, rbr, hold;
  logic          hold_v;
  int            ix;
  logic          req, known, bad_w, bad_r, wr_go, rd_go;
  logic          dlab, loop, thr_wr, rbr_rd, live_dr;
  logic [BW-1:0] live, rbr_next, rd_val;

  assign ix      = 32'(bus_addr[AW-1:2]);
  assign req     = bus_wr | bus_rd;
  assign known   = (bus_addr[1:0] == 2'b00) && (ix <= SL_SCR || ix == SL_GCTL);
  assign bad_w   = req && bus_size != SZ16;
  assign bad_r   = req && bus_size == SZ16 && !known;
  assign wr_go   = req && !bad_w && !bad_r && bus_wr;
  assign rd_go   = req && !bad_w && !bad_r && !bus_wr;
  assign dlab    = lctl[DLAB_BIT];
  assign loop    = mctl[LOOP_BIT];
  assign thr_wr  = wr_go && ix == SL_DATA && !dlab;
  assign rbr_rd  = rd_go && ix == SL_DATA && !dlab;
  assign live_dr = hold_v | (!loop & rx_valid);
  assign live    = BW'({tx_ready, tx_ready, 4'b0000, live_dr});
  assign rx_take = rbr_rd && !hold_v && !loop && rx_valid;
  assign rbr_next = hold_v ? hold : (rx_take ? rx_data : rbr);

  always_comb begin
    case (ix)
      SL_DATA:  rd_val = dlab ? dll : rbr_next;
      SL_IEN:   rd_val = dlab ? dlh : ien;
      SL_IDENT: rd_val = BW'(1);
      SL_LCTL:  rd_val = lctl;
      SL_MCTL:  rd_val = mctl;
      SL_LSTAT: rd_val = lstat | live;
      SL_SCR:   rd_val = scr;
      SL_GCTL:  rd_val = gctl;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll <= BW'(1); dlh <= '0; ien <= '0; lctl <= '0; mctl <= '0;
      lstat <= BW'(8'h60); scr <= '0; gctl <= '0; rbr <= '0;
      hold <= '0; hold_v <= 1'b0;
      bus_rdata <= '0; bus_err <= 2'b00;
      tx_data <= '0; tx_valid <= 1'b0; ev_tx <= 1'b0; ev_rx <= 1'b0;
    end else begin
      bus_err  <= {bad_r, bad_w};
      tx_valid <= thr_wr;
      ev_tx    <= thr_wr & ien[1];
      ev_rx    <= ien[0] & live_dr;
      if (rd_go) bus_rdata <= DW'(rd_val);
      if (thr_wr) tx_data <= bus_wdata[BW-1:0];
      if (rbr_rd) begin
        rbr    <= rbr_next;
        hold_v <= 1'b0;
      end
      if (rd_go && ix == SL_LSTAT) lstat <= '0;
      if (wr_go) begin
        case (ix)
          SL_DATA: begin
            if (dlab) dll <= bus_wdata[BW-1:0];
            else if (loop) begin
              hold   <= bus_wdata[BW-1:0];
              hold_v <= 1'b1;
            end
          end
          SL_IEN:  if (dlab) dlh <= bus_wdata[BW-1:0]; else ien <= bus_wdata[BW-1:0];
          SL_LCTL: lctl <= bus_wdata[BW-1:0];
          SL_MCTL: mctl <= bus_wdata[BW-1:0];
          SL_SCR:  scr  <= bus_wdata[BW-1:0];
          SL_GCTL: gctl <= bus_wdata[BW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [1:0]    bus_err,
  input logic [BW-1:0] tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [BW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_take,
  input logic          ev_tx,
  input logic          ev_rx
);
  // R11
  width_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && bus_size != 2'd1 |=> bus_err == 2'b01);
  // R11
  idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> bus_err == 2'b00);
  // R5
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr) && $past(bus_size) == 2'd1);
  // R5
  tx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_data == $past(bus_wdata[BW-1:0]));
  // R6
  ev_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |-> tx_valid);
  // R9
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> rx_valid && bus_rd && !bus_wr);
endmodule

bind uart_regbank uart_regbank_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (.*);

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic [1:0]  bus_size = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [1:0]  bus_err;
  logic [7:0]  tx_data, rx_data = 0;
  logic        tx_valid, tx_ready = 1, rx_valid = 0, rx_take, ev_tx, ev_rx;
  int n_chk = 0, n_fail = 0;

  uart_regbank i_uart_regbank (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] sz, output logic [15:0] rd,
                     output logic [1:0] e, output logic tk);
    @(negedge clk);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d; bus_size = sz;
    #1 tk = rx_take;
    @(negedge clk);
    rd = bus_rdata; e = bus_err;
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] r; logic [1:0] e; logic t;
    acc(1, a, d, 2'd1, r, e, t);
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input int exp);
    logic [15:0] r; logic [1:0] e; logic t;
    acc(0, a, 0, 2'd1, r, e, t);
    check(req, r, exp);
  endtask

  task automatic t_reset;
    tx_ready = 0;
    rdchk("R1 lstat stored", 8'h14, 16'h0060);
    rdchk("R4 lstat cleared", 8'h14, 16'h0000);
    tx_ready = 1;
    rdchk("R1 ident", 8'h08, 1);
    rdchk("R1 ien", 8'h04, 0);
    rdchk("R1 lctl", 8'h0C, 0);
    rdchk("R1 mctl", 8'h10, 0);
    rdchk("R1 scr", 8'h1C, 0);
    rdchk("R1 gctl", 8'h24, 0);
    wr(8'h0C, 16'h0080);
    rdchk("R1 dll", 8'h00, 1);
    rdchk("R1 dlh", 8'h04, 0);
    wr(8'h0C, 0);
  endtask

  task automatic t_alias;
    wr(8'h0C, 16'h0080);
    wr(8'h00, 16'h0034);
    check("R2 no tx on divisor write", tx_valid, 0);
    wr(8'h04, 16'h0012);
    wr(8'h0C, 0);
    wr(8'h04, 16'h0003);
    rdchk("R2 ien view", 8'h04, 3);
    wr(8'h0C, 16'h0080);
    rdchk("R2 dlh view", 8'h04, 16'h0012);
    rdchk("R2 dll view", 8'h00, 16'h0034);
    wr(8'h0C, 0);
    wr(8'h04, 0);
  endtask

  task automatic t_store;
    wr(8'h1C, 16'hA5A5);
    rdchk("R3 scr low byte", 8'h1C, 16'h00A5);
    wr(8'h24, 16'h120F);
    rdchk("R3 gctl", 8'h24, 16'h000F);
    wr(8'h10, 16'h0003);
    rdchk("R3 mctl", 8'h10, 3);
    wr(8'h10, 0);
    wr(8'h08, 16'h00FF);
    rdchk("R3 ident write ignored", 8'h08, 1);
    wr(8'h18, 16'h00FF);
    rdchk("R3 mstat write ignored", 8'h18, 0);
    tx_ready = 0;
    wr(8'h14, 16'h00FF);
    rdchk("R3 lstat write ignored", 8'h14, 0);
    tx_ready = 1;
    rdchk("R4 live tx bits", 8'h14, 16'h0060);
  endtask

  task automatic t_tx;
    wr(8'h00, 16'h015A);
    check("R5 tx_valid", tx_valid, 1);
    check("R5 tx_data", tx_data, 8'h5A);
    check("R6 no ev_tx when disabled", ev_tx, 0);
    @(negedge clk);
    check("R5 single pulse", tx_valid, 0);
    wr(8'h04, 16'h0002);
    wr(8'h00, 16'h0033);
    check("R6 ev_tx", ev_tx, 1);
    check("R6 tx_data", tx_data, 8'h33);
    wr(8'h04, 0);
  endtask

  task automatic t_rx;
    logic [15:0] r; logic [1:0] e; logic t;
    rx_data = 8'h77; rx_valid = 1;
    rdchk("R12 data ready", 8'h14, 16'h0061);
    acc(0, 8'h00, 0, 2'd1, r, e, t);
    check("R9 rx_take", t, 1);
    check("R9 rx byte", r, 8'h77);
    rx_valid = 0; rx_data = 8'h11;
    acc(0, 8'h00, 0, 2'd1, r, e, t);
    check("R9 no take when empty", t, 0);
    check("R9 previous value", r, 8'h77);
    rdchk("R12 no data ready", 8'h14, 16'h0060);
  endtask

  task automatic t_loop;
    logic [15:0] r; logic [1:0] e; logic t;
    wr(8'h10, 16'h0010);
    rx_data = 8'h99; rx_valid = 1;
    rdchk("R8 ext ignored in lstat", 8'h14, 16'h0060);
    wr(8'h00, 16'h00C3);
    check("R7 tx still sent", tx_valid, 1);
    rdchk("R12 hold sets data ready", 8'h14, 16'h0061);
    acc(0, 8'h00, 0, 2'd1, r, e, t);
    check("R7 loop byte", r, 8'hC3);
    check("R8 no take in loop", t, 0);
    acc(0, 8'h00, 0, 2'd1, r, e, t);
    check("R8 previous in loop", r, 8'hC3);
    check("R8 ext not consumed", t, 0);
    rdchk("R7 hold emptied", 8'h14, 16'h0060);
    rx_valid = 0;
    wr(8'h10, 0);
  endtask

  task automatic t_evrx;
    wr(8'h04, 16'h0001);
    @(negedge clk);
    check("R10 no ev without data", ev_rx, 0);
    rx_valid = 1; rx_data = 8'h44;
    @(negedge clk);
    check("R10 ev_rx rises", ev_rx, 1);
    wr(8'h04, 0);
    @(negedge clk);
    check("R10 ev_rx stops", ev_rx, 0);
    rx_valid = 0;
  endtask

  task automatic t_err;
    logic [15:0] r; logic [1:0] e; logic t;
    acc(0, 8'h28, 0, 2'd0, r, e, t);
    check("R11 width priority", e, 2'b01);
    acc(0, 8'h28, 0, 2'd1, r, e, t);
    check("R11 beyond map", e, 2'b10);
    acc(0, 8'h20, 0, 2'd1, r, e, t);
    check("R11 gap slot", e, 2'b10);
    acc(0, 8'h02, 0, 2'd1, r, e, t);
    check("R11 unaligned", e, 2'b10);
    acc(1, 8'h1C, 16'h0055, 2'd2, r, e, t);
    check("R11 bad width write", e, 2'b01);
    check("R11 bad write no tx", tx_valid, 0);
    acc(1, 8'h00, 16'h0066, 2'd0, r, e, t);
    check("R11 bad width thr no tx", tx_valid, 0);
    rx_valid = 1; rx_data = 8'h5C;
    acc(0, 8'h00, 0, 2'd2, r, e, t);
    check("R11 bad read no take", t, 0);
    rx_valid = 0;
    acc(0, 8'h1C, 0, 2'd1, r, e, t);
    check("R11 good access no error", e, 2'b00);
    check("R11 scr unchanged", r, 16'h00A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_alias;
    t_store;
    t_tx;
    t_rx;
    t_loop;
    t_evrx;
    t_err;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule